// File: doc/BRIEF.md
# Cascadable Range Counter

This block is a synchronous binary up-counter of a parameterised width (four bits by default) with a synchronous clear, a synchronous parallel load and a count enable. A terminal-count flag marks the all-ones state. A gated version of that flag, `casc_en`, lets several instances form a wider counter. Each instance takes the gated flag of the one below it as its own enable.

A small range controller sits in front of the counter. It reuses the same load and clear paths to restrict the counting range, and a two-bit `mode` input picks one of four behaviours:
- **Free** (`00`): the counter wraps from all-ones to zero.
- **Start-offset** (`01`): at the all-ones state the counter reloads `start_val`.
- **End-offset** (`10`): on reaching `end_val` the counter clears to zero.
- **Window** (`11`): on reaching `end_val` the counter reloads `start_val`.

Every enabled clock edge resolves to one named action. The actions are CLEAR, LOAD, HOLD, STEP, RESTART (load `start_val`) and WRAP (clear on end match). The transitions between actions follow a fixed priority:
1. `clr` selects CLEAR.
2. Otherwise `ld` selects LOAD.
3. Otherwise a low `en` selects HOLD.
4. Otherwise the mode and the current count choose STEP, RESTART or WRAP.

Top module: `rc_range_counter`

## Requirements
- R1: On a rising edge with `clr` high, `count` becomes 0, whatever `ld`, `en` and `mode` are.
- R2: On a rising edge with `clr` low and `ld` high, `count` takes `din`, whatever `en` and `mode` are. `din[WIDTH-1]` is the MSB, so `din`=1000 gives `count`=1000.
- R3: With `clr`, `ld` and `en` all low, `count` keeps its value across the edge in every mode.
- R4: In free mode (`mode`=00) an enabled edge adds 1 to `count` modulo 2^WIDTH, so 1111 is followed by 0000.
- R5: `carry` is 1 exactly when `count` is all ones, independent of `en`.
- R6: `casc_en` is `carry` AND `en`. Two instances, with the upper one's `en` driven by the lower one's `casc_en`, count as one 8-bit free-running counter that advances only on enabled cycles.
- R7: In start-offset mode (`mode`=01), an enabled edge at `count`=1111 loads `start_val`; other enabled edges increment.
- R8: In end-offset mode (`mode`=10), an enabled edge with `count`==`end_val` clears `count` to 0; other enabled edges increment.
- R9: In window mode (`mode`=11), an enabled edge with `count`==`end_val` loads `start_val`; other enabled edges increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Synchronous clear, highest priority |
| ld | input | 1 | Synchronous parallel load of `din` |
| en | input | 1 | Count enable |
| mode | input | 2 | Range mode: 00 free, 01 start-offset, 10 end-offset, 11 window |
| din | input | WIDTH | Parallel load value, MSB first |
| start_val | input | WIDTH | Restart value for start-offset and window modes |
| end_val | input | WIDTH | Match value for end-offset and window modes |
| count | output | WIDTH | Current count |
| carry | output | 1 | High when `count` is all ones |
| casc_en | output | 1 | `carry` qualified by `en`, the enable for the next stage |

## Verification
The bound checker examines every cycle once the first clear has been seen. It checks the priority of clear over load and of load over enable, holding when disabled, the free-mode increment, the restart and wrap actions of the three range modes, and the gating of `casc_en`. Some behaviour needs a long run and can only be shown by the bench's scenarios:
- the 8-bit cascade carrying across the nibble boundary over more than a full wrap, with enable gaps;
- the repeating start-offset and end-offset sequences over several periods, compared against an independent model.

// File: rtl/rc_pkg.sv
package rc_pkg;

    typedef enum logic [1:0] {
        MODE_FREE   = 2'b00,
        MODE_START  = 2'b01,
        MODE_END    = 2'b10,
        MODE_WINDOW = 2'b11
    } rc_mode_e;

    typedef enum logic [2:0] {
        ACT_CLEAR,
        ACT_LOAD,
        ACT_HOLD,
        ACT_STEP,
        ACT_RESTART,
        ACT_WRAP
    } rc_act_e;

endpackage

// File: rtl/rc_toggle_counter.sv
module rc_toggle_counter #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             sync_clr,
    input  logic             sync_ld,
    input  logic             cnt_en,
    input  logic [WIDTH-1:0] ld_val,
    output logic [WIDTH-1:0] q,
    output logic             term
);

    logic [WIDTH-1:0] tog;

    // bit i flips when enabled and all lower bits are one
    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_tog
            if (i == 0) begin : g_lsb
                assign tog[i] = cnt_en;
            end else begin : g_upper
                assign tog[i] = cnt_en & (&q[i-1:0]);
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (sync_clr) begin
            q <= '0;
        end else if (sync_ld) begin
            q <= ld_val;
        end else begin
            q <= q ^ tog;
        end
    end

    assign term = &q;

endmodule

// File: rtl/rc_range_ctrl.sv
module rc_range_ctrl
    import rc_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  rc_mode_e         mode,
    input  logic             clr,
    input  logic             ld,
    input  logic             en,
    input  logic [WIDTH-1:0] din,
    input  logic [WIDTH-1:0] start_val,
    input  logic [WIDTH-1:0] end_val,
    input  logic [WIDTH-1:0] q,
    input  logic             term,
    output logic             do_clr,
    output logic             do_ld,
    output logic             do_cnt,
    output logic [WIDTH-1:0] ld_val
);

    rc_act_e act;
    logic    end_hit;

    assign end_hit = (q == end_val);

    // action selection: clear > load > hold > mode-specific
    always_comb begin
        if (clr) begin
            act = ACT_CLEAR;
        end else if (ld) begin
            act = ACT_LOAD;
        end else if (!en) begin
            act = ACT_HOLD;
        end else begin
            unique case (mode)
                MODE_FREE:   act = ACT_STEP;
                MODE_START:  act = term    ? ACT_RESTART : ACT_STEP;
                MODE_END:    act = end_hit ? ACT_WRAP    : ACT_STEP;
                MODE_WINDOW: act = end_hit ? ACT_RESTART : ACT_STEP;
            endcase
        end
    end

    // action to counter controls
    always_comb begin
        do_clr = 1'b0;
        do_ld  = 1'b0;
        do_cnt = 1'b0;
        ld_val = din;
        unique case (act)
            ACT_CLEAR:   do_clr = 1'b1;
            ACT_LOAD:    do_ld  = 1'b1;
            ACT_HOLD:    do_cnt = 1'b0;
            ACT_STEP:    do_cnt = 1'b1;
            ACT_RESTART: begin
                do_ld  = 1'b1;
                ld_val = start_val;
            end
            ACT_WRAP:    do_clr = 1'b1;
            default:     do_cnt = 1'b0;
        endcase
    end

endmodule

// File: rtl/rc_range_counter.sv
module rc_range_counter
    import rc_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             ld,
    input  logic             en,
    input  logic [1:0]       mode,
    input  logic [WIDTH-1:0] din,
    input  logic [WIDTH-1:0] start_val,
    input  logic [WIDTH-1:0] end_val,
    output logic [WIDTH-1:0] count,
    output logic             carry,
    output logic             casc_en
);

    logic             do_clr;
    logic             do_ld;
    logic             do_cnt;
    logic [WIDTH-1:0] ld_val;
    logic             term;

    rc_range_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .mode      (rc_mode_e'(mode)),
        .clr       (clr),
        .ld        (ld),
        .en        (en),
        .din       (din),
        .start_val (start_val),
        .end_val   (end_val),
        .q         (count),
        .term      (term),
        .do_clr    (do_clr),
        .do_ld     (do_ld),
        .do_cnt    (do_cnt),
        .ld_val    (ld_val)
    );

    rc_toggle_counter #(.WIDTH(WIDTH)) u_cnt (
        .clk      (clk),
        .sync_clr (do_clr),
        .sync_ld  (do_ld),
        .cnt_en   (do_cnt),
        .ld_val   (ld_val),
        .q        (count),
        .term     (term)
    );

    assign carry   = term;
    assign casc_en = term & en;

endmodule

// File: rtl/rc_range_counter_chk.sv
module rc_range_counter_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             clr,
    input logic             ld,
    input logic             en,
    input logic [1:0]       mode,
    input logic [WIDTH-1:0] din,
    input logic [WIDTH-1:0] start_val,
    input logic [WIDTH-1:0] end_val,
    input logic [WIDTH-1:0] count,
    input logic             carry,
    input logic             casc_en
);

    localparam logic [WIDTH-1:0] ALL1 = '1;

    logic primed = 1'b0;
    always_ff @(posedge clk) begin
        if (clr) primed <= 1'b1;
    end

    p_clear_r1: assert property (@(posedge clk) disable iff (!primed)
        clr |=> (count == '0));

    p_load_r2: assert property (@(posedge clk) disable iff (!primed)
        (!clr && ld) |=> (count == $past(din)));

    p_hold_r3: assert property (@(posedge clk) disable iff (!primed)
        (!clr && !ld && !en) |=> $stable(count));

    p_free_step_r4: assert property (@(posedge clk) disable iff (!primed)
        (!clr && !ld && en && mode == 2'b00) |=> (count == $past(count) + 1'b1));

    p_casc_gate_r6: assert property (@(posedge clk) disable iff (!primed)
        casc_en |-> (en && count == ALL1));

    p_restart_r7: assert property (@(posedge clk) disable iff (!primed)
        (!clr && !ld && en && mode == 2'b01 && count == ALL1) |=> (count == $past(start_val)));

    p_wrap_r8: assert property (@(posedge clk) disable iff (!primed)
        (!clr && !ld && en && mode == 2'b10 && count == end_val) |=> (count == '0));

    p_window_r9: assert property (@(posedge clk) disable iff (!primed)
        (!clr && !ld && en && mode == 2'b11 && count == end_val) |=> (count == $past(start_val)));

    always_comb begin
        if (primed) begin
            a_carry_r5: assert (carry == (count == ALL1));
        end
    end

endmodule

bind rc_range_counter rc_range_counter_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .clr       (clr),
    .ld        (ld),
    .en        (en),
    .mode      (mode),
    .din       (din),
    .start_val (start_val),
    .end_val   (end_val),
    .count     (count),
    .carry     (carry),
    .casc_en   (casc_en)
);

// File: tb/sim_rc_range_counter.sv
module sim_rc_range_counter;

    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC = 19;

    // row: clr, ld, en, mode[2], din[4], start[4], end[4], exp_count[4], exp_carry
    localparam logic [21:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 1'b0, 2'd0, 4'h0, 4'h0, 4'h0, 4'h0, 1'b0}, // R1 reset state
        {1'b0, 1'b1, 1'b0, 2'd0, 4'hA, 4'h0, 4'h0, 4'hA, 1'b0}, // R2 load
        {1'b0, 1'b0, 1'b1, 2'd0, 4'h0, 4'h0, 4'h0, 4'hB, 1'b0}, // R4 step
        {1'b0, 1'b0, 1'b0, 2'd0, 4'h3, 4'h0, 4'h0, 4'hB, 1'b0}, // R3 hold
        {1'b0, 1'b1, 1'b1, 2'd0, 4'hE, 4'h0, 4'h0, 4'hE, 1'b0}, // R2 load beats enable
        {1'b0, 1'b0, 1'b1, 2'd0, 4'h0, 4'h0, 4'h0, 4'hF, 1'b1}, // R5 carry at 1111
        {1'b0, 1'b0, 1'b0, 2'd0, 4'h0, 4'h0, 4'h0, 4'hF, 1'b1}, // R5 carry without en
        {1'b0, 1'b0, 1'b1, 2'd0, 4'h0, 4'h0, 4'h0, 4'h0, 1'b0}, // R4 wrap
        {1'b1, 1'b1, 1'b1, 2'd1, 4'h5, 4'h6, 4'h0, 4'h0, 1'b0}, // R1 clear beats load
        {1'b0, 1'b1, 1'b0, 2'd1, 4'hF, 4'h6, 4'h0, 4'hF, 1'b1}, // R2 load 1111
        {1'b0, 1'b0, 1'b1, 2'd1, 4'h0, 4'h6, 4'h0, 4'h6, 1'b0}, // R7 restart
        {1'b0, 1'b0, 1'b1, 2'd1, 4'h0, 4'h6, 4'h0, 4'h7, 1'b0}, // R7 step
        {1'b0, 1'b1, 1'b0, 2'd2, 4'hC, 4'h0, 4'hD, 4'hC, 1'b0}, // R2 load
        {1'b0, 1'b0, 1'b1, 2'd2, 4'h0, 4'h0, 4'hD, 4'hD, 1'b0}, // R8 step to end
        {1'b0, 1'b0, 1'b1, 2'd2, 4'h0, 4'h0, 4'hD, 4'h0, 1'b0}, // R8 wrap to 0
        {1'b0, 1'b1, 1'b0, 2'd3, 4'h9, 4'h3, 4'h9, 4'h9, 1'b0}, // R2 load
        {1'b0, 1'b0, 1'b1, 2'd3, 4'h0, 4'h3, 4'h9, 4'h3, 1'b0}, // R9 restart at end
        {1'b0, 1'b0, 1'b1, 2'd3, 4'h0, 4'h3, 4'h9, 4'h4, 1'b0}, // R9 step
        {1'b0, 1'b1, 1'b0, 2'd0, 4'h8, 4'h0, 4'h0, 4'h8, 1'b0}  // R2 MSB position
    };

    logic       clk = 1'b0;
    logic       c_clr = 1'b0, c_ld = 1'b0, c_en = 1'b0;
    logic [1:0] c_mode = 2'd0;
    logic [3:0] c_din = '0, c_start = '0, c_end = '0;
    logic [3:0] lo_cnt, hi_cnt;
    logic       lo_carry, hi_carry, lo_casc, hi_casc;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rc_range_counter #(.WIDTH(4)) u0 (
        .clk(clk), .clr(c_clr), .ld(c_ld), .en(c_en), .mode(c_mode),
        .din(c_din), .start_val(c_start), .end_val(c_end),
        .count(lo_cnt), .carry(lo_carry), .casc_en(lo_casc)
    );

    rc_range_counter #(.WIDTH(4)) u1 (
        .clk(clk), .clr(c_clr), .ld(1'b0), .en(lo_casc), .mode(2'd0),
        .din(4'h0), .start_val(4'h0), .end_val(4'h0),
        .count(hi_cnt), .carry(hi_carry), .casc_en(hi_casc)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin : main
        logic [3:0] m;
        logic [7:0] m8;
        @(negedge clk);
        // table walk: drive at negedge, check at the next negedge
        for (int k = 0; k < NVEC; k++) begin
            {c_clr, c_ld, c_en, c_mode, c_din, c_start, c_end} = VEC[k][21:5];
            @(negedge clk);
            check($sformatf("R1-table row %0d count", k), {12'h0, lo_cnt}, {12'h0, VEC[k][4:1]});
            check($sformatf("R5 row %0d carry", k), {15'h0, lo_carry}, {15'h0, VEC[k][0]});
            check($sformatf("R6 row %0d casc_en", k), {15'h0, lo_casc},
                  {15'h0, VEC[k][0] & c_en});
        end

        // R6: 8-bit cascade with enable gaps, more than one full wrap
        c_ld = 1'b0; c_mode = 2'd0; c_clr = 1'b1; c_en = 1'b0;
        @(negedge clk);
        c_clr = 1'b0;
        m8 = 8'h00;
        check("R1 cascade clear", {8'h0, hi_cnt, lo_cnt}, 16'h0);
        for (int k = 0; k < 600; k++) begin
            c_en = (k % 7) != 3;
            if (c_en) m8 = m8 + 8'd1;
            @(negedge clk);
            check("R6 cascade count", {8'h0, hi_cnt, lo_cnt}, {8'h0, m8});
        end

        // R7: start-offset, more than two periods
        c_en = 1'b1; c_mode = 2'd1; c_start = 4'h6;
        m = lo_cnt;
        for (int k = 0; k < 40; k++) begin
            m = (m == 4'hF) ? 4'h6 : m + 4'd1;
            @(negedge clk);
            check("R7 start-offset seq", {12'h0, lo_cnt}, {12'h0, m});
        end

        // R8: end-offset, more than two periods
        c_mode = 2'd2; c_end = 4'hD;
        c_clr = 1'b1;
        @(negedge clk);
        c_clr = 1'b0;
        m = 4'h0;
        for (int k = 0; k < 45; k++) begin
            m = (m == 4'hD) ? 4'h0 : m + 4'd1;
            @(negedge clk);
            check("R8 end-offset seq", {12'h0, lo_cnt}, {12'h0, m});
        end

        // R3: hold in window mode at the end value
        c_mode = 2'd3; c_start = 4'h2; c_end = lo_cnt; c_en = 1'b0;
        m = lo_cnt;
        repeat (3) @(negedge clk);
        check("R3 hold at end match", {12'h0, lo_cnt}, {12'h0, m});
        c_en = 1'b1;
        @(negedge clk);
        check("R9 window restart", {12'h0, lo_cnt}, 16'h0002);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R1 watchdog: actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule